// File: doc/BRIEF.md
# Bridge Forwarding Address Decoder

This block sits on the upstream side of a bus-to-bus bridge and decides, for each transaction presented to it, whether the bridge should claim it and pass it to the downstream bus. It keeps the programmable windows that make this decision:
- a 32-bit I/O window with 4KB granularity;
- a non-prefetchable memory window with 1MB granularity;
- a prefetchable memory window with 1MB granularity that spans 64-bit addresses.

It also keeps the bus-number pair used to route hierarchical configuration accesses, and four enable bits. Two of the enables gate the I/O and memory command classes. The other two turn on the legacy-friendly ISA hole and the VGA I/O decode.

A request is one cycle wide. It carries:
- a command class;
- a 64-bit address, used for I/O and memory;
- an 8-bit bus number, used for configuration.

One cycle later the block reports three things: whether the request is claimed, a code naming the window that matched, and whether a configuration access must be converted to Type 0. Registers are written and read back through a flat indexed port. A write takes effect from the next cycle on.

Top module: `bridge_fwd_decoder`

## Requirements
- R1: After reset all stored fields are zero: window bounds, upper registers, bus numbers and the enable bits. The forward outputs stay low until a request arrives.
- R2: The register map is as follows.
  - Index 0: I/O base in bits 7:4 and I/O limit in bits 15:12. Bits 3:0 and 11:8 read back the constant 1, which marks 32-bit I/O.
  - Index 1: I/O base upper half in bits 15:0 and I/O limit upper half in bits 31:16.
  - Index 2: memory base in bits 15:4 and memory limit in bits 31:20. The low nibbles read 0.
  - Index 3: prefetchable base in bits 15:4 and prefetchable limit in bits 31:20. The low nibbles read 1, which marks 64-bit capability.
  - Index 4: prefetchable base upper 32 bits.
  - Index 5: prefetchable limit upper 32 bits.
  - Index 6: secondary bus number in bits 7:0 and subordinate bus number in bits 15:8.
  - Index 7: enable bits. Bit 0 enables I/O, bit 1 enables memory, bit 2 enables the ISA hole and bit 3 enables VGA.
- R3: An I/O request (class 1) matches the I/O window, code 2, when its address lies inside the window. The window's lower bound is {base upper, base nibble, 12'h000}. Its upper bound is {limit upper, limit nibble, 12'hFFF}. Both bounds are inclusive.
- R4: With VGA enabled, an I/O request whose address bits 31:16 are zero and whose bits 9:0 lie in 3B0h–3BBh or 3C0h–3DFh is claimed with code 1. This holds for any value of bits 15:10.
- R5: With the ISA hole enabled, an I/O request whose bits 31:16 are zero and whose bits 9:8 are nonzero is not claimed, even inside the I/O window.
- R6: A single-address memory request (class 2) matches the memory window, code 3, when address bits 31:0 lie between {base,20'h0} and {limit,20'hFFFFF}.
- R7: The prefetchable window, code 4, has the 64-bit bounds {base upper, base, 20'h0} and {limit upper, limit, 20'hFFFFF}.
  - A dual-address request (class 3) is claimed only by this window, using all 64 address bits.
  - A single-address request is tested against it with the upper 32 bits taken as zero.
- R8: Priority when more than one rule applies:
  - For I/O, the VGA match comes first, then the ISA hole, then the I/O window.
  - For memory, the memory window wins over the prefetchable window.
- R9: A window whose lower bound exceeds its upper bound matches nothing.
- R10: With the I/O enable clear, no I/O request is claimed. With the memory enable clear, no memory request of either class is claimed.
- R11: A Type 1 configuration request (class 4) is routed by its bus number.
  - A bus number above the secondary number and not above the subordinate number is forwarded with code 5.
  - A bus number equal to the secondary number is claimed with code 6 and raises the Type 0 flag.
  - Any other bus number is not claimed.
  - Class 0 is never claimed.
- R12: The outputs are registered and report the request of the previous cycle. When no request was present, the valid flag, the hit flag, the window code and the Type 0 flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register index |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the selected index |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Command class: 0 none, 1 I/O, 2 memory single, 3 memory dual, 4 config Type 1 |
| req_addr | input | 64 | Transaction address |
| req_bus | input | 8 | Target bus number for configuration |
| fwd_valid | output | 1 | Result present |
| fwd_hit | output | 1 | Request claimed for downstream |
| fwd_win | output | 3 | Matched window code |
| fwd_type0 | output | 1 | Configuration to be converted to Type 0 |

## Verification
The hardest situation to reach is one where several decode rules apply to the same address at once. An example is a VGA alias that falls inside both the ISA hole and the I/O window. Another is a memory address covered by both memory windows. The stimulus programs overlapping windows on purpose and places the I/O window over the first VGA aliases. It then sweeps every fourth I/O address of the low 32KB under all four ISA/VGA combinations, so each alias and each hole edge is met in both priority orders. Dual-address sweeps follow after the prefetchable upper registers are moved off zero, which separates 64-bit matches from matches on the low 32 bits.

// File: rtl/bridge_fwd_decoder.sv
module bridge_fwd_decoder #(
  parameter int BUS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [63:0]       req_addr,
  input  logic [BUS_W-1:0]  req_bus,
  output logic              fwd_valid,
  output logic              fwd_hit,
  output logic [2:0]        fwd_win,
  output logic              fwd_type0
);
  logic [3:0]       io_base_n, io_lim_n;
  logic [15:0]      io_base_up, io_lim_up;
  logic [11:0]      mem_base, mem_lim, pf_base, pf_lim;
  logic [31:0]      pf_base_up, pf_lim_up;
  logic [BUS_W-1:0] sec_bus, sub_bus;
  logic             io_en, mem_en, isa_en, vga_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_base_n  <= '0; io_lim_n  <= '0;
      io_base_up <= '0; io_lim_up <= '0;
      mem_base   <= '0; mem_lim   <= '0;
      pf_base    <= '0; pf_lim    <= '0;
      pf_base_up <= '0; pf_lim_up <= '0;
      sec_bus    <= '0; sub_bus   <= '0;
      io_en <= 1'b0; mem_en <= 1'b0; isa_en <= 1'b0; vga_en <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0: begin io_base_n <= cfg_wdata[7:4]; io_lim_n <= cfg_wdata[15:12]; end
        3'd1: begin io_base_up <= cfg_wdata[15:0]; io_lim_up <= cfg_wdata[31:16]; end
        3'd2: begin mem_base <= cfg_wdata[15:4]; mem_lim <= cfg_wdata[31:20]; end
        3'd3: begin pf_base <= cfg_wdata[15:4]; pf_lim <= cfg_wdata[31:20]; end
        3'd4: pf_base_up <= cfg_wdata;
        3'd5: pf_lim_up  <= cfg_wdata;
        3'd6: begin sec_bus <= cfg_wdata[BUS_W-1:0]; sub_bus <= cfg_wdata[8+BUS_W-1:8]; end
        default: begin
          io_en  <= cfg_wdata[0]; mem_en <= cfg_wdata[1];
          isa_en <= cfg_wdata[2]; vga_en <= cfg_wdata[3];
        end
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_sel)
      3'd0: cfg_rdata = {16'h0, io_lim_n, 4'h1, io_base_n, 4'h1};
      3'd1: cfg_rdata = {io_lim_up, io_base_up};
      3'd2: cfg_rdata = {mem_lim, 4'h0, mem_base, 4'h0};
      3'd3: cfg_rdata = {pf_lim, 4'h1, pf_base, 4'h1};
      3'd4: cfg_rdata = pf_base_up;
      3'd5: cfg_rdata = pf_lim_up;
      3'd6: cfg_rdata[8+BUS_W-1:0] = {sub_bus, sec_bus};
      default: cfg_rdata[3:0] = {vga_en, isa_en, mem_en, io_en};
    endcase
  end

  wire [31:0] a32    = req_addr[31:0];
  wire        low64k = (a32[31:16] == 16'h0);
  wire [9:0]  a10    = a32[9:0];

  wire [31:0] io_lo  = {io_base_up, io_base_n, 12'h000};
  wire [31:0] io_hi  = {io_lim_up, io_lim_n, 12'hfff};
  wire        io_in  = (io_lo <= a32) && (a32 <= io_hi);
  wire        vga_in = vga_en && low64k &&
                       (((a10 >= 10'h3b0) && (a10 <= 10'h3bb)) ||
                        ((a10 >= 10'h3c0) && (a10 <= 10'h3df)));
  wire        isa_out = isa_en && low64k && (a32[9:8] != 2'b00);

  wire [31:0] mem_lo = {mem_base, 20'h0};
  wire [31:0] mem_hi = {mem_lim, 20'hfffff};
  wire        mem_in = (mem_lo <= a32) && (a32 <= mem_hi);

  wire [63:0] pf_addr = (req_kind == 3'd3) ? req_addr : {32'h0, a32};
  wire [63:0] pf_lo   = {pf_base_up, pf_base, 20'h0};
  wire [63:0] pf_hi   = {pf_lim_up, pf_lim, 20'hfffff};
  wire        pf_in   = (pf_lo <= pf_addr) && (pf_addr <= pf_hi);

  logic       d_hit, d_t0;
  logic [2:0] d_win;

  always_comb begin
    d_hit = 1'b0; d_win = 3'd0; d_t0 = 1'b0;
    case (req_kind)
      3'd1: if (io_en) begin
        if (vga_in)       begin d_hit = 1'b1; d_win = 3'd1; end
        else if (isa_out) d_hit = 1'b0;
        else if (io_in)   begin d_hit = 1'b1; d_win = 3'd2; end
      end
      3'd2: if (mem_en) begin
        if (mem_in)     begin d_hit = 1'b1; d_win = 3'd3; end
        else if (pf_in) begin d_hit = 1'b1; d_win = 3'd4; end
      end
      3'd3: if (mem_en && pf_in) begin d_hit = 1'b1; d_win = 3'd4; end
      3'd4: begin
        if (req_bus == sec_bus) begin d_hit = 1'b1; d_win = 3'd6; d_t0 = 1'b1; end
        else if ((req_bus > sec_bus) && (req_bus <= sub_bus)) begin d_hit = 1'b1; d_win = 3'd5; end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0; fwd_hit <= 1'b0; fwd_win <= 3'd0; fwd_type0 <= 1'b0;
    end else begin
      fwd_valid <= req_valid;
      fwd_hit   <= req_valid & d_hit;
      fwd_win   <= req_valid ? d_win : 3'd0;
      fwd_type0 <= req_valid & d_t0;
    end
  end
endmodule

// File: rtl/bridge_fwd_decoder_chk.sv
module bridge_fwd_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [2:0]  req_kind,
  input logic [63:0] req_addr,
  input logic [7:0]  req_bus,
  input logic        fwd_valid,
  input logic        fwd_hit,
  input logic [2:0]  fwd_win,
  input logic        fwd_type0,
  input logic        io_en,
  input logic        mem_en,
  input logic        isa_en,
  input logic        vga_en,
  input logic [7:0]  sec_bus
);
  assert_valid_lat_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> fwd_valid);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_valid |-> (!fwd_hit && fwd_win == 3'd0 && !fwd_type0));

  assert_io_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd1 && !io_en) |=> !fwd_hit);

  assert_mem_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_kind == 3'd2 || req_kind == 3'd3) && !mem_en) |=> !fwd_hit);

  assert_isa_hole_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd1 && isa_en && !vga_en &&
     req_addr[31:16] == 16'h0 && req_addr[9:8] != 2'b00) |=> !fwd_hit);

  assert_type0_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd4 && req_bus == sec_bus) |=> (fwd_type0 && fwd_win == 3'd6));

  assert_dual_pref_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd3) |=> (fwd_win == 3'd0 || fwd_win == 3'd4));
endmodule

bind bridge_fwd_decoder bridge_fwd_decoder_chk chk_i (.*);

// File: tb/bridge_fwd_decoder_tb_top.sv
module bridge_fwd_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = '0;
  logic [63:0] req_addr = '0;
  logic [7:0]  req_bus = '0;
  logic        fwd_valid, fwd_hit, fwd_type0;
  logic [2:0]  fwd_win;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bridge_fwd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_kind(req_kind), .req_addr(req_addr), .req_bus(req_bus),
    .fwd_valid(fwd_valid), .fwd_hit(fwd_hit), .fwd_win(fwd_win), .fwd_type0(fwd_type0)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // shadow of programmed state
  logic [3:0]  s_iob = 0, s_iol = 0;
  logic [15:0] s_ioub = 0, s_ioul = 0;
  logic [11:0] s_mb = 0, s_ml = 0, s_pb = 0, s_pl = 0;
  logic [31:0] s_pub = 0, s_pul = 0;
  logic [7:0]  s_sec = 0, s_sub = 0;
  logic [3:0]  s_ctl = 0;

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      3'd0: begin s_iob = d[7:4]; s_iol = d[15:12]; end
      3'd1: begin s_ioub = d[15:0]; s_ioul = d[31:16]; end
      3'd2: begin s_mb = d[15:4]; s_ml = d[31:20]; end
      3'd3: begin s_pb = d[15:4]; s_pl = d[31:20]; end
      3'd4: s_pub = d;
      3'd5: s_pul = d;
      3'd6: begin s_sec = d[7:0]; s_sub = d[15:8]; end
      default: s_ctl = d[3:0];
    endcase
  endtask

  task automatic rd_check(input logic [2:0] sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_sel = sel;
    #1;
    checks++;
    if (cfg_rdata !== exp) begin
      errors++;
      $display("FAIL %s: rdata[%0d] actual %h expected %h", tag, sel, cfg_rdata, exp);
    end
  endtask

  // expected {type0, hit, win}
  function automatic logic [4:0] model(input logic [2:0] k, input logic [63:0] a, input logic [7:0] b);
    longint unsigned lo, hi, x;
    logic [9:0] t;
    logic low;
    x = a[31:0];
    low = (a[31:16] == 0);
    t = a[9:0];
    case (k)
      3'd1: begin
        if (!s_ctl[0]) return 5'b0;
        if (s_ctl[3] && low && ((t >= 10'h3b0 && t <= 10'h3bb) || (t >= 10'h3c0 && t <= 10'h3df)))
          return {2'b01, 3'd1};
        if (s_ctl[2] && low && a[9:8] != 0) return 5'b0;
        lo = s_ioub * 65536 + s_iob * 4096;
        hi = s_ioul * 65536 + s_iol * 4096 + 4095;
        if (x >= lo && x <= hi) return {2'b01, 3'd2};
        return 5'b0;
      end
      3'd2, 3'd3: begin
        if (!s_ctl[1]) return 5'b0;
        if (k == 3'd2) begin
          lo = s_mb * 1048576; hi = s_ml * 1048576 + 1048575;
          if (x >= lo && x <= hi) return {2'b01, 3'd3};
        end else x = a;
        lo = {s_pub, s_pb, 20'h0}; hi = {s_pul, s_pl, 20'hfffff};
        if (x >= lo && x <= hi) return {2'b01, 3'd4};
        return 5'b0;
      end
      3'd4: begin
        if (b == s_sec) return {2'b11, 3'd6};
        if (b > s_sec && b <= s_sub) return {2'b01, 3'd5};
        return 5'b0;
      end
      default: return 5'b0;
    endcase
  endfunction

  task automatic req(input logic [2:0] k, input logic [63:0] a, input logic [7:0] b, input string tag);
    logic [4:0] e;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_bus = b;
    e = model(k, a, b);
    @(negedge clk);
    req_valid = 1'b0;
    checks++;
    if (fwd_valid !== 1'b1 || {fwd_type0, fwd_hit, fwd_win} !== e) begin
      errors++;
      $display("FAIL %s: kind %0d addr %h bus %0d actual v%b t0%b h%b w%0d expected t0%b h%b w%0d",
               tag, k, a, b, fwd_valid, fwd_type0, fwd_hit, fwd_win, e[4], e[3], e[2:0]);
    end
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    checks++;
    if ({fwd_valid, fwd_hit, fwd_win, fwd_type0} !== 6'b0) begin
      errors++;
      $display("FAIL %s: idle outputs actual v%b h%b w%0d t0%b expected all zero",
               tag, fwd_valid, fwd_hit, fwd_win, fwd_type0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    idle_check("R1");
    rd_check(3'd0, 32'h0000_0101, "R1");
    rd_check(3'd3, 32'h0001_0001, "R1");
    rd_check(3'd6, 32'h0, "R1");
    rd_check(3'd7, 32'h0, "R1");
    req(3'd1, 64'h0, 8'd0, "R1");
    // R2 readback codes
    wr(3'd0, 32'hffff_ffff); rd_check(3'd0, 32'h0000_f1f1, "R2");
    wr(3'd2, 32'hffff_ffff); rd_check(3'd2, 32'hfff0_fff0, "R2");
    wr(3'd3, 32'hffff_ffff); rd_check(3'd3, 32'hfff1_fff1, "R2");
    wr(3'd6, 32'hffff_ffff); rd_check(3'd6, 32'h0000_ffff, "R2");
    wr(3'd7, 32'hffff_ffff); rd_check(3'd7, 32'h0000_000f, "R2");
    wr(3'd1, 32'h1234_5678); rd_check(3'd1, 32'h1234_5678, "R2");
    // I/O window 0x0000..0x5FFF (base nibble 0) to overlap VGA aliases
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h5000);
    for (int m = 0; m < 4; m++) begin
      wr(3'd7, 32'h1 | (m << 2));
      for (int a = 0; a < 32'h8000; a += 4) req(3'd1, a, 0, "R3 R4 R5 R8");
      req(3'd1, 64'h3bb, 0, "R4"); req(3'd1, 64'h3bc, 0, "R4");
      req(3'd1, 64'h3af, 0, "R4"); req(3'd1, 64'hfcdf, 0, "R4");
      req(3'd1, 64'h5fff, 0, "R3"); req(3'd1, 64'h6000, 0, "R3");
    end
    // upper I/O bits, alias off above 64KB
    wr(3'd7, 32'hd);
    wr(3'd0, 32'h5020); wr(3'd1, 32'h0001_0001);
    req(3'd1, 64'h1_2000, 0, "R3"); req(3'd1, 64'h1_1fff, 0, "R3");
    req(3'd1, 64'h1_5fff, 0, "R3"); req(3'd1, 64'h1_6000, 0, "R3");
    req(3'd1, 64'h2000, 0, "R3"); req(3'd1, 64'h1_03c0, 0, "R4");
    req(3'd1, 64'h1_2100, 0, "R5");
    // R10 io disabled
    wr(3'd7, 32'hc);
    req(3'd1, 64'h1_2000, 0, "R10"); req(3'd1, 64'h3c0, 0, "R10");
    // R9 inverted I/O window
    wr(3'd7, 32'h1); wr(3'd0, 32'h1050);
    req(3'd1, 64'h1_1000, 0, "R9"); req(3'd1, 64'h1_5000, 0, "R9");
    // memory windows overlapping
    wr(3'd2, 32'h1250_1230);
    wr(3'd3, 32'h2000_1240);
    wr(3'd4, 32'h0); wr(3'd5, 32'h0);
    wr(3'd7, 32'h2);
    for (int i = 0; i < 8192; i++) req(3'd2, 64'(i) << 19, 0, "R6 R7 R8");
    req(3'd2, 64'h122f_ffff, 0, "R6"); req(3'd2, 64'h1230_0000, 0, "R6");
    req(3'd2, 64'h125f_ffff, 0, "R8"); req(3'd2, 64'h1260_0000, 0, "R7");
    req(3'd2, 64'h200f_ffff, 0, "R7"); req(3'd2, 64'h2010_0000, 0, "R7");
    req(3'd2, 64'h5_1240_0000, 0, "R7");
    // dual-address
    wr(3'd4, 32'h1); wr(3'd5, 32'h1);
    for (int i = 0; i < 2048; i++) begin
      req(3'd3, {32'h1, 32'(i) << 21}, 0, "R7");
      req(3'd3, {32'h0, 32'(i) << 21}, 0, "R7");
      req(3'd3, {32'h2, 32'(i) << 21}, 0, "R7");
    end
    req(3'd3, 64'h1_123f_ffff, 0, "R7"); req(3'd3, 64'h1_1240_0000, 0, "R7");
    req(3'd2, 64'h1240_0000, 0, "R7");
    req(3'd2, 64'h1280_0000, 0, "R7");
    // R10 memory disabled
    wr(3'd7, 32'h1);
    req(3'd2, 64'h1240_0000, 0, "R10"); req(3'd3, 64'h1_1240_0000, 0, "R10");
    // R9 inverted memory window
    wr(3'd7, 32'h2); wr(3'd2, 32'h1000_2000);
    req(3'd2, 64'h1000_0000, 0, "R9"); req(3'd2, 64'h1800_0000, 0, "R9");
    // R11 bus routing
    wr(3'd6, 32'h0000_0905);
    for (int b = 0; b < 256; b++) req(3'd4, 0, b[7:0], "R11");
    req(3'd0, 64'h1240_0000, 8'd5, "R11");
    idle_check("R12");
    wr(3'd6, 32'h0000_0408);
    for (int b = 0; b < 16; b++) req(3'd4, 0, b[7:0], "R11");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule